// File: doc/BRIEF.md
# Carry-Select Block Adder

This block is a purely combinational unsigned adder of parameterised width. The word is cut into consecutive slices whose lengths come from a parameter array, and the slices need not be equal. The least significant slice is an ordinary ripple adder fed by the external carry-in.

Every slice above it holds two ripple adders that work at the same time. One assumes the slice receives no carry. The other assumes it receives one. As soon as the real carry out of the slice below is known, a two-way select picks the matching sum and carry. Each carry therefore crosses a slice through one select instead of through a full ripple chain.

With the default slice lengths 4, 5, 6, 7 and 10 over 32 bits, the slice boundaries sit at bits 4, 9, 15 and 22. The lengths grow toward the top, so the upper slices have more time to settle while the selected carry climbs.

Top module: `csel_adder`

## Requirements
- R1: For every input combination, the 33-bit value {cout, sum} equals the unsigned sum a + b + cin.
- R2: The block has no clock and no storage, and its outputs follow a change of a, b or cin without any clock edge.
- R3: The lowest slice's sum bits depend only on the low bits of a and b in that slice and on cin.
- R4: The carry that enters each upper slice equals the carry out of the true addition of all bits below that slice's lowest bit. With the default lengths these boundaries are bits 4, 9, 15 and 22.
- R5: An upper slice outputs its no-carry result when its incoming carry is 0 and its plus-one result when its incoming carry is 1. This holds even when the whole slice propagates, which is the case a = all ones within the slice and b = 0.
- R6: When a XOR b is all ones, cin = 1 gives sum = 0 with cout = 1, and cin = 0 gives sum = all ones with cout = 0.
- R7: cout is 1 exactly when a + b + cin is at least 2^WIDTH. With a = b = all ones and cin = 1, the result is sum = all ones and cout = 1.
- R8: The slice lengths are a parameter array of NUM_BLK entries. Elaboration fails if they do not add up to WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
Random operands seldom produce a carry that is born in the lowest slice and then runs through every slice above it. That case is the one in which each select must take its plus-one result in turn. The stimulus builds it on purpose. For each boundary it sets a to all ones below the boundary, b to zero and cin to one, so the carry lands exactly at that boundary. It repeats the pattern with cin at zero and adds full-propagate words, so each select is seen taking both of its inputs.

// File: rtl/csel_pkg.sv
package csel_pkg;

    // sum and carry of one bit position
    typedef struct packed {
        logic c;
        logic s;
    } bit_res_t;

endpackage

// File: rtl/csel_ha.sv
module csel_ha
    import csel_pkg::*;
(
    input  logic x,
    input  logic y,
    output logic s,
    output logic c
);
    bit_res_t res_d;

    always_comb begin
        res_d.s = x ^ y;
        res_d.c = x & y;
    end

    assign s = res_d.s;
    assign c = res_d.c;
endmodule

// File: rtl/csel_fa.sv
module csel_fa
    import csel_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    bit_res_t res_d;
    logic     hx_d;

    always_comb begin
        hx_d    = x ^ y;
        res_d.s = hx_d ^ ci;
        res_d.c = (x & y) | (hx_d & ci);
    end

    assign s  = res_d.s;
    assign co = res_d.c;
endmodule

// File: rtl/csel_ripple.sv
module csel_ripple #(
    parameter int unsigned LEN        = 4,
    parameter bit          HALF_FIRST = 1'b0
) (
    input  logic [LEN-1:0] a,
    input  logic [LEN-1:0] b,
    input  logic           ci,
    output logic [LEN-1:0] s,
    output logic           co
);
    logic [LEN:0] chain_d;

    if (HALF_FIRST) begin : g_half0
        // carry-in is known to be zero: the first stage needs no carry input
        logic unused_ci;
        assign unused_ci = ci;
        assign chain_d[0] = 1'b0;
        csel_ha u_ha (
            .x(a[0]),
            .y(b[0]),
            .s(s[0]),
            .c(chain_d[1])
        );
    end else begin : g_full0
        assign chain_d[0] = ci;
        csel_fa u_fa (
            .x (a[0]),
            .y (b[0]),
            .ci(chain_d[0]),
            .s (s[0]),
            .co(chain_d[1])
        );
    end

    for (genvar i = 1; i < LEN; i++) begin : g_bit
        csel_fa u_fa (
            .x (a[i]),
            .y (b[i]),
            .ci(chain_d[i]),
            .s (s[i]),
            .co(chain_d[i+1])
        );
    end

    assign co = chain_d[LEN];
endmodule

// File: rtl/csel_block.sv
module csel_block #(
    parameter int unsigned LEN = 4
) (
    input  logic [LEN-1:0] a,
    input  logic [LEN-1:0] b,
    input  logic           sel_c,
    output logic [LEN-1:0] s,
    output logic           co
);
    logic [LEN-1:0] s0_d, s1_d;
    logic           c0_d, c1_d;

    csel_ripple #(.LEN(LEN), .HALF_FIRST(1'b1)) u_zero (
        .a (a),
        .b (b),
        .ci(1'b0),
        .s (s0_d),
        .co(c0_d)
    );

    csel_ripple #(.LEN(LEN), .HALF_FIRST(1'b0)) u_one (
        .a (a),
        .b (b),
        .ci(1'b1),
        .s (s1_d),
        .co(c1_d)
    );

    always_comb begin
        if (sel_c) begin
            s  = s1_d;
            co = c1_d;
        end else begin
            s  = s0_d;
            co = c0_d;
        end
    end
endmodule

// File: rtl/csel_adder.sv
module csel_adder #(
    parameter int unsigned WIDTH   = 32,
    parameter int unsigned NUM_BLK = 5,
    parameter int unsigned BLK_LEN [NUM_BLK] = '{4, 5, 6, 7, 10}
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    function automatic int unsigned blk_lo(int unsigned k);
        int unsigned acc = 0;
        for (int unsigned i = 0; i < k; i++) acc += BLK_LEN[i];
        return acc;
    endfunction

    localparam int unsigned TOTAL_LEN = blk_lo(NUM_BLK);

    // R8: slice lengths must tile the word exactly
    if (TOTAL_LEN != WIDTH) begin : g_bad_split
        $error("csel_adder: slice lengths add to %0d, WIDTH is %0d", TOTAL_LEN, WIDTH);
    end

    // blk_c[k] is the resolved carry into slice k
    logic [NUM_BLK:0] blk_c;
    assign blk_c[0] = cin;

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
        localparam int unsigned LO = blk_lo(g);
        localparam int unsigned LN = BLK_LEN[g];
        if (g == 0) begin : g_base
            csel_ripple #(.LEN(LN), .HALF_FIRST(1'b0)) u_base (
                .a (a[LO +: LN]),
                .b (b[LO +: LN]),
                .ci(blk_c[0]),
                .s (sum[LO +: LN]),
                .co(blk_c[1])
            );
        end else begin : g_sel
            csel_block #(.LEN(LN)) u_sel (
                .a    (a[LO +: LN]),
                .b    (b[LO +: LN]),
                .sel_c(blk_c[g]),
                .s    (sum[LO +: LN]),
                .co   (blk_c[g+1])
            );
        end
    end

    assign cout = blk_c[NUM_BLK];
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
    parameter int unsigned WIDTH   = 32,
    parameter int unsigned NUM_BLK = 5,
    parameter int unsigned BLK_LEN [NUM_BLK] = '{4, 5, 6, 7, 10}
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [NUM_BLK:0] blk_c
);
    function automatic int unsigned lo_of(int unsigned k);
        int unsigned acc = 0;
        for (int unsigned i = 0; i < k; i++) acc += BLK_LEN[i];
        return acc;
    endfunction

    logic [WIDTH:0] full_ref;

    always_comb begin
        full_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        p_total_r1: assert ({cout, sum} == full_ref)
            else $error("R1: adder result mismatch");
        if (&(a ^ b)) begin
            p_propagate_r6: assert (sum == {WIDTH{~cin}} && cout == cin)
                else $error("R6: full-propagate result wrong");
        end
        if (&a && &b && cin) begin
            p_maxval_r7: assert (&sum && cout)
                else $error("R7: maximum operands wrong");
        end
    end

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_chk
        localparam int unsigned LO = lo_of(g);
        localparam int unsigned LN = BLK_LEN[g];
        logic [LN:0] slice_ref;
        always_comb begin
            slice_ref = {1'b0, a[LO +: LN]} + {1'b0, b[LO +: LN]} + {{LN{1'b0}}, blk_c[g]};
            if (g == 0) begin
                p_base_r3: assert ({blk_c[1], sum[LN-1:0]} == slice_ref)
                    else $error("R3: lowest slice wrong");
            end else begin
                p_select_r5: assert ({blk_c[g+1], sum[LO +: LN]} == slice_ref)
                    else $error("R5: upper slice picked wrong result");
            end
        end
        if (g > 0) begin : g_bnd
            logic [LO:0] below_ref;
            always_comb begin
                below_ref = {1'b0, a[LO-1:0]} + {1'b0, b[LO-1:0]} + {{LO{1'b0}}, cin};
                p_bcarry_r4: assert (blk_c[g] == below_ref[LO])
                    else $error("R4: boundary carry wrong");
            end
        end
    end
endmodule

bind csel_adder csel_adder_chk #(
    .WIDTH  (WIDTH),
    .NUM_BLK(NUM_BLK),
    .BLK_LEN(BLK_LEN)
) u_chk (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout),
    .blk_c(blk_c)
);

// File: tb/csel_adder_tb.sv
`timescale 1ns/1ps
module csel_adder_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0, b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    csel_adder u_dut (
        .a   (a),
        .b   (b),
        .cin (cin),
        .sum (sum),
        .cout(cout)
    );

    // {cin, a, b}
    localparam logic [64:0] VEC [12] = '{
        {1'b0, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 32'hFFFF_FFFF, 32'h0000_0001},
        {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b0, 32'h8000_0000, 32'h8000_0000},
        {1'b0, 32'h1234_5678, 32'h8765_4321},
        {1'b1, 32'hAAAA_AAAA, 32'h5555_5555},
        {1'b0, 32'hAAAA_AAAA, 32'h5555_5555},
        {1'b1, 32'h0000_000F, 32'h0000_0000},
        {1'b0, 32'h0000_01F0, 32'h0000_0010},
        {1'b1, 32'h7FFF_FFFF, 32'h0000_0000},
        {1'b0, 32'hDEAD_BEEF, 32'hCAFE_F00D}
    };

    localparam int BND [4] = '{4, 9, 15, 22};

    task automatic check(string req, logic [W:0] got, logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic apply(logic [W-1:0] va, logic [W-1:0] vb, logic vc);
        @(negedge clk);
        a = va; b = vb; cin = vc;
        #1;
    endtask

    function automatic logic [W:0] ref_add(logic [W-1:0] va, logic [W-1:0] vb, logic vc);
        return {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog got=1 exp=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // R1: idle state with zero inputs
        check("R1 reset", {cout, sum}, '0);

        // R1 R7: vector table
        for (int i = 0; i < 12; i++) begin
            apply(VEC[i][63:32], VEC[i][31:0], VEC[i][64]);
            check("R1 table", {cout, sum}, ref_add(VEC[i][63:32], VEC[i][31:0], VEC[i][64]));
        end

        // R7: largest operands
        apply('1, '1, 1'b1);
        check("R7 max", {cout, sum}, {1'b1, {W{1'b1}}});

        // R6: full propagate both carry values
        apply(32'hF0F0_3C3C, 32'h0F0F_C3C3, 1'b1);
        check("R6 prop cin1", {cout, sum}, {1'b1, {W{1'b0}}});
        apply(32'hF0F0_3C3C, 32'h0F0F_C3C3, 1'b0);
        check("R6 prop cin0", {cout, sum}, {1'b0, {W{1'b1}}});

        // R4 R5: carry landing exactly on each slice boundary, and not landing
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] m;
            m = (32'h1 << BND[k]) - 32'h1;
            apply(m, '0, 1'b1);
            check("R4 boundary carry", {cout, sum}, {1'b0, 32'h1 << BND[k]});
            apply(m, '0, 1'b0);
            check("R5 no carry", {cout, sum}, {1'b0, m});
            // slice above the boundary fully propagating
            apply(~m, 32'h0, 1'b1);
            check("R5 upper propagate", {cout, sum}, ref_add(~m, '0, 1'b1));
        end

        // R3: lowest slice unaffected by upper bits
        apply(32'hFFFF_FFF5, 32'h0000_0003, 1'b1);
        check("R3 low slice", {28'h0, sum[3:0]}, {29'h0, 4'h9});
        apply(32'h0000_0005, 32'h1230_0003, 1'b1);
        check("R3 low slice upper varied", {28'h0, sum[3:0]}, {29'h0, 4'h9});

        // R2: output follows inputs mid-cycle with no clock edge between
        @(posedge clk);
        #0.5;
        a = 32'h0000_0100; b = 32'h0000_0200; cin = 1'b0;
        #1;
        check("R2 combinational", {cout, sum}, {1'b0, 32'h0000_0300});

        // R1: random vectors
        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] ra, rb;
            logic rc;
            ra = $urandom; rb = $urandom; rc = 1'($urandom);
            apply(ra, rb, rc);
            check("R1 random", {cout, sum}, ref_add(ra, rb, rc));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule